// File: doc/BRIEF.md
# Multi-Device SPI Master with Stored Device Profiles

This block is a synchronous SPI master. A host writes a data word, chooses a target device and a frame count, and the block then clocks a full-duplex exchange on SCLK, MOSI and MISO. While one word goes out, the word coming back from the slave is assembled in the receive register.

A small table holds one configuration profile per chip-select line. Each profile sets the clock idle level, the sampling edge, the bit order on the wire, the frame length in bits and the SCLK divider. When a transfer is accepted, the profile that belongs to the addressed device is copied into the working setting, so switching between devices with different needs costs the host nothing. Frames shorter than the data word use its low-order bits. A burst count repeats the frame several times under one chip-select assertion. At the end of a burst the block sets a done flag and, if enabled, pulses an interrupt. An abort input drops the chip select at once and returns the block to idle.

Top module: `spi_multi_master`

## Requirements
- R1: After reset every cs_n line is high, sclk, mosi, busy, done, irq and rx_valid are low, and every profile holds mode 0, MSB first, a DW-bit frame and divider 0.
- R2: A write with cfg_we stores {cfg_cpol, cfg_cpha, cfg_lsb, cfg_len, cfg_div} as the profile of device cfg_dev. A start uses the profile of dev_sel. During the transfer only cs_n[dev_sel] goes low, and at most one cs_n line is low at any time.
- R3: The mode number is {cpol, cpha}. sclk takes the profile's idle level cpol before the chip select falls and returns to it at the end. With cpha=0 the slave's data is sampled on the first, third, ... SCLK edges of each frame and MOSI changes on the others. With cpha=1 MOSI changes on the first, third, ... edges and sampling happens on the second, fourth, ....
- R4: With divider value N, each SCLK half-period lasts N+1 system clocks. Chip select falls N+1 clocks before the first SCLK edge and rises N+1 clocks after the last edge of the burst.
- R5: A frame has cfg_len+1 bits, which is 2*(cfg_len+1) SCLK edges. Only bits cfg_len..0 of tx_data are sent. rx_data holds the received bits right-aligned, with every higher bit zero.
- R6: With lsb=0, bit cfg_len goes on the wire first. With lsb=1, bit 0 goes first. The same order applies to received data.
- R7: At the end of each frame rx_valid pulses for one cycle, and rx_data holds the word received in that frame.
- R8: burst_len=B gives B+1 frames of the latched tx word under one continuous chip-select assertion, with the SCLK edges keeping an even spacing across frame boundaries.
- R9: done is set when chip select is released at the end of a burst. irq pulses for one cycle at that moment if irq_en was high. done clears on rd_ack or on a new start.
- R10: start_we while busy is ignored. The running transfer keeps its device, word, profile and frame count, and no new transfer follows.
- R11: abort during a transfer raises all cs_n lines, clears busy and returns sclk to its idle level on the next clock edge, and done is not set. A later start works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write the profile of cfg_dev |
| cfg_dev | input | SELW | Device whose profile is written |
| cfg_cpol | input | 1 | Profile SCLK idle level |
| cfg_cpha | input | 1 | Profile phase: 1 samples on trailing edges |
| cfg_lsb | input | 1 | Profile bit order: 1 sends LSB first |
| cfg_len | input | LENW | Profile frame length minus one |
| cfg_div | input | DIVW | Profile divider N (half-period N+1 clocks) |
| start_we | input | 1 | Data write: start a transfer when idle |
| dev_sel | input | SELW | Target device for the start |
| tx_data | input | DW | Word to send, right-aligned |
| burst_len | input | BW | Number of frames minus one |
| irq_en | input | 1 | Enable the completion interrupt for this start |
| rd_ack | input | 1 | Host has read rx_data; clears done |
| abort | input | 1 | Abort the running transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Burst finished |
| irq | output | 1 | One-cycle completion pulse |
| rx_data | output | DW | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse at the end of each frame |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
The hardest case to reach from the ports is a device switch in the middle of other activity. The profile table is rewritten, or a second start is written, while a burst is running on a different device with another mode, bit order and length. The random phase reprograms profiles between transfers and moves across all four devices in random order, with random lengths from 1 to DW bits, dividers, burst counts and bit orders. The directed cases write a start to another device during a burst, abort part of the way through a frame, and run the 1-bit and full-width frames and the longest burst. A behavioural slave follows the mode of the addressed profile. It captures MOSI and returns its own random words, so both the transmit order and the receive alignment are compared against words the bench chose.

// File: rtl/spi_mm_pkg.sv
// Shared types for the multi-device SPI master.
// Assumes nothing beyond IEEE 1800-2017 packages.
package spi_mm_pkg;

    // Transfer sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,   // chip selects high, waiting for a start
        ST_PREP,   // one clock: polarity applied, chip select still high
        ST_LEAD,   // chip select low, half-period before the first edge
        ST_XFER,   // SCLK edges running
        ST_TRAIL   // half-period after the last edge of the burst
    } spi_state_e;

endpackage

// File: rtl/spi_mm_profiles.sv
// Per-device configuration table.
// Holds one packed profile word per chip select. Writes happen on any cycle;
// the read port is combinational and is only sampled by the top at a start.
// Assumes rsel and wsel are below NCS; an out-of-range read returns RST.
module spi_mm_profiles #(
    parameter int NCS = 4,
    parameter int PW  = 15,
    parameter logic [PW-1:0] RST = '0,
    localparam int SELW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [SELW-1:0] wsel,
    input  logic [PW-1:0]   wdata,
    input  logic [SELW-1:0] rsel,
    output logic [PW-1:0]   rdata
);

    logic [PW-1:0] prof_q [NCS];

    for (genvar i = 0; i < NCS; i++) begin : g_entry
        // Storage for the profile of device i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prof_q[i] <= RST;
            end else if (we && (wsel == SELW'(i))) begin
                prof_q[i] <= wdata;
            end
        end
    end

    // Read the profile of the addressed device
    always_comb begin
        rdata = RST;
        for (int j = 0; j < NCS; j++) begin
            if (rsel == SELW'(j)) begin
                rdata = prof_q[j];
            end
        end
    end

endmodule

// File: rtl/spi_mm_tick.sv
// Half-period timer.
// While en is high, tick pulses once every div+1 clocks, starting div+1
// clocks after en rises. The count restarts from zero whenever en is low.
module spi_mm_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DIVW-1:0] div,
    output logic            tick
);

    logic [DIVW-1:0] cnt_q;

    assign tick = en && (cnt_q == div);

    // Count system clocks inside one half-period
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_mm_shift.sv
// Bit engine for one frame at a time.
// Counts SCLK edges inside the frame, drives MOSI on the shift edges and
// places MISO samples at their right-aligned bit position on the sample
// edges. Wire bit k maps to word bit k (LSB first) or len-k (MSB first).
// Assumes len < DW and that the edge strobe comes at most once per clock.
module spi_mm_shift #(
    parameter int DW = 16,
    localparam int LENW = (DW > 1) ? $clog2(DW) : 1,
    localparam int EW   = LENW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            clear,
    input  logic            edge_stb,
    input  logic            cpha,
    input  logic            lsb,
    input  logic [LENW-1:0] len,
    input  logic [DW-1:0]   txw,
    input  logic            miso,
    output logic            mosi,
    output logic            last_edge,
    output logic [DW-1:0]   rx_data,
    output logic            rx_valid
);

    logic [EW-1:0]   e_q;
    logic [DW-1:0]   acc_q;
    logic [DW-1:0]   acc_nxt;
    logic [LENW-1:0] k;
    logic [LENW-1:0] k_next;
    logic            sample;
    logic            at_end;

    assign k         = e_q[EW-1:1];
    assign sample    = cpha ? e_q[0] : !e_q[0];
    assign at_end    = (e_q == {len, 1'b1});
    assign last_edge = edge_stb && at_end;
    assign k_next    = at_end ? '0 : k + 1'b1;

    // Word position of a wire bit index
    function automatic logic [LENW-1:0] widx(input logic [LENW-1:0] b,
                                              input logic lsb_f,
                                              input logic [LENW-1:0] l);
        return lsb_f ? b : l - b;
    endfunction

    // Receive word including the bit sampled on this edge
    always_comb begin
        acc_nxt = acc_q;
        if (edge_stb && sample) begin
            acc_nxt[widx(k, lsb, len)] = miso;
        end
    end

    // Edge counter, MOSI driver and receive assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q      <= '0;
            acc_q    <= '0;
            mosi     <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (clear) begin
                e_q   <= '0;
                acc_q <= '0;
            end else if (load) begin
                e_q   <= '0;
                acc_q <= '0;
                if (!cpha) begin
                    mosi <= txw[widx('0, lsb, len)];
                end
            end else if (edge_stb) begin
                if (!sample) begin
                    if (cpha) begin
                        mosi <= txw[widx(k, lsb, len)];
                    end else begin
                        mosi <= txw[widx(k_next, lsb, len)];
                    end
                end
                if (at_end) begin
                    e_q      <= '0;
                    acc_q    <= '0;
                    rx_data  <= acc_nxt;
                    rx_valid <= 1'b1;
                end else begin
                    e_q   <= e_q + 1'b1;
                    acc_q <= acc_nxt;
                end
            end
        end
    end

endmodule

// File: rtl/spi_multi_master.sv
// Multi-device SPI master, top level.
// Accepts a start only when idle, latches the addressed device's profile,
// then runs PREP -> LEAD -> XFER -> TRAIL. Chip select is low from LEAD to
// the end of TRAIL. Done, interrupt and SCLK level are kept here. The
// profile table, half-period timer and bit engine are submodules.
// Assumes host inputs are synchronous to clk and dev_sel < NCS.
module spi_multi_master
    import spi_mm_pkg::*;
#(
    parameter int NCS  = 4,
    parameter int DW   = 16,
    parameter int DIVW = 8,
    parameter int BW   = 3,
    localparam int SELW = (NCS > 1) ? $clog2(NCS) : 1,
    localparam int LENW = (DW > 1) ? $clog2(DW) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [SELW-1:0] cfg_dev,
    input  logic            cfg_cpol,
    input  logic            cfg_cpha,
    input  logic            cfg_lsb,
    input  logic [LENW-1:0] cfg_len,
    input  logic [DIVW-1:0] cfg_div,
    input  logic            start_we,
    input  logic [SELW-1:0] dev_sel,
    input  logic [DW-1:0]   tx_data,
    input  logic [BW-1:0]   burst_len,
    input  logic            irq_en,
    input  logic            rd_ack,
    input  logic            abort,
    output logic            busy,
    output logic            done,
    output logic            irq,
    output logic [DW-1:0]   rx_data,
    output logic            rx_valid,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic [NCS-1:0]  cs_n
);

    localparam int PW = 3 + LENW + DIVW;

    typedef struct packed {
        logic            cpol;
        logic            cpha;
        logic            lsb;
        logic [LENW-1:0] len;
        logic [DIVW-1:0] div;
    } prof_t;

    localparam prof_t RST_PROF = '{cpol: 1'b0, cpha: 1'b0, lsb: 1'b0,
                                   len: LENW'(DW - 1), div: '0};

    spi_state_e      st_q;
    prof_t           prof_wr;
    prof_t           prof_rd;
    prof_t           cur_q;
    logic [SELW-1:0] sel_q;
    logic [DW-1:0]   txw_q;
    logic [BW-1:0]   frames_q;
    logic            active;
    logic            accept;
    logic            kill;
    logic            tick;
    logic            edge_stb;
    logic            last_edge;
    logic            finish;

    assign prof_wr  = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb: cfg_lsb,
                        len: cfg_len, div: cfg_div};
    assign busy     = (st_q != ST_IDLE);
    assign active   = (st_q == ST_LEAD) || (st_q == ST_XFER) || (st_q == ST_TRAIL);
    assign accept   = (st_q == ST_IDLE) && start_we;
    assign kill     = busy && abort;
    assign edge_stb = tick && !abort && ((st_q == ST_LEAD) || (st_q == ST_XFER));
    assign finish   = (st_q == ST_TRAIL) && tick && !abort;

    spi_mm_profiles #(.NCS(NCS), .PW(PW), .RST(RST_PROF)) u_prof (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wsel  (cfg_dev),
        .wdata (prof_wr),
        .rsel  (dev_sel),
        .rdata (prof_rd)
    );

    spi_mm_tick #(.DIVW(DIVW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active),
        .div   (cur_q.div),
        .tick  (tick)
    );

    spi_mm_shift #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (st_q == ST_PREP),
        .clear     (kill),
        .edge_stb  (edge_stb),
        .cpha      (cur_q.cpha),
        .lsb       (cur_q.lsb),
        .len       (cur_q.len),
        .txw       (txw_q),
        .miso      (miso),
        .mosi      (mosi),
        .last_edge (last_edge),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    // Transfer sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else if (kill) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE:  if (start_we) st_q <= ST_PREP;
                ST_PREP:  st_q <= ST_LEAD;
                ST_LEAD:  if (tick) st_q <= ST_XFER;
                ST_XFER:  if (last_edge && (frames_q == '0)) st_q <= ST_TRAIL;
                ST_TRAIL: if (tick) st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Latch device, word and profile at an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= RST_PROF;
            sel_q <= '0;
            txw_q <= '0;
        end else if (accept) begin
            cur_q <= prof_rd;
            sel_q <= dev_sel;
            txw_q <= tx_data;
        end
    end

    // Frames still to run after the current one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frames_q <= '0;
        end else if (accept) begin
            frames_q <= burst_len;
        end else if (last_edge && (frames_q != '0)) begin
            frames_q <= frames_q - 1'b1;
        end
    end

    // Serial clock level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk <= 1'b0;
        end else if (accept) begin
            sclk <= prof_rd.cpol;
        end else if (kill) begin
            sclk <= cur_q.cpol;
        end else if (edge_stb) begin
            sclk <= !sclk;
        end
    end

    // Completion flag and interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (finish) begin
                done <= 1'b1;
                irq  <= irq_en;
            end else if (accept || rd_ack) begin
                done <= 1'b0;
            end
        end
    end

    // Active-low chip select decode
    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = !(active && (sel_q == SELW'(i)));
    end

endmodule

// File: rtl/spi_mm_chk.sv
// Assertion checker for spi_multi_master, attached by bind below.
// Observes ports plus the latched device and profile.
module spi_mm_chk #(
    parameter int NCS  = 4,
    parameter int SELW = 2,
    parameter int PW   = 15
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCS-1:0]  cs_n,
    input logic            sclk,
    input logic            busy,
    input logic            done,
    input logic            irq,
    input logic            irq_en,
    input logic            rd_ack,
    input logic            abort,
    input logic            start_we,
    input logic [SELW-1:0] sel_q,
    input logic [PW-1:0]   cur_q
);

    a_r2_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    a_r10_latched_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(sel_q) && $stable(cur_q));

    a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy && abort |=> !busy && (&cs_n));

    a_r3_sclk_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start_we |=> $stable(sclk));

    a_r4_no_edge_at_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $past(&cs_n) && !(&cs_n) |-> $stable(sclk));

    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r9_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done && $past(irq_en));

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && !busy |=> !done);

endmodule

bind spi_multi_master spi_mm_chk #(.NCS(NCS), .SELW(SELW), .PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .busy     (busy),
    .done     (done),
    .irq      (irq),
    .irq_en   (irq_en),
    .rd_ack   (rd_ack),
    .abort    (abort),
    .start_we (start_we),
    .sel_q    (sel_q),
    .cur_q    (cur_q)
);

// File: tb/test_spi_multi_master.sv
// Self-checking bench: behavioural slave, edge/timing monitor, directed
// corners plus seeded random transfers across all devices.
module test_spi_multi_master;

    localparam int NCS  = 4;
    localparam int DW   = 16;
    localparam int DIVW = 8;
    localparam int BW   = 3;
    localparam int SELW = 2;
    localparam int LENW = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_we, cfg_cpol, cfg_cpha, cfg_lsb;
    logic [SELW-1:0] cfg_dev, dev_sel;
    logic [LENW-1:0] cfg_len;
    logic [DIVW-1:0] cfg_div;
    logic            start_we, irq_en, rd_ack, abort;
    logic [DW-1:0]   tx_data;
    logic [BW-1:0]   burst_len;
    logic            busy, done, irq, rx_valid, sclk, mosi, miso;
    logic [DW-1:0]   rx_data;
    logic [NCS-1:0]  cs_n;

    always #2 clk = ~clk;

    spi_multi_master #(.NCS(NCS), .DW(DW), .DIVW(DIVW), .BW(BW)) i_spi_multi_master (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dev(cfg_dev),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb(cfg_lsb),
        .cfg_len(cfg_len), .cfg_div(cfg_div), .start_we(start_we),
        .dev_sel(dev_sel), .tx_data(tx_data), .burst_len(burst_len),
        .irq_en(irq_en), .rd_ack(rd_ack), .abort(abort), .busy(busy),
        .done(done), .irq(irq), .rx_data(rx_data), .rx_valid(rx_valid),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int nchk = 0;
    int nerr = 0;

    // bench copy of the profile table
    bit bp_cpol [NCS];
    bit bp_cpha [NCS];
    bit bp_lsb  [NCS];
    int bp_len  [NCS];
    int bp_div  [NCS];

    // current transfer model
    bit m_cpol, m_cpha, m_lsb;
    int m_len;
    logic [DW-1:0] s_words [8];
    bit got [8][DW];

    // monitor state
    int since, lead, trail, hmin, hmax, edges, mframes, irq_cnt;
    bit first, lvl_cs, cs_prev, sclk_prev;
    logic [NCS-1:0] cs_mask;

    wire cs_act = ~&cs_n;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit sbit(input int f, input int k);
        logic [DW-1:0] w = s_words[f & 7];
        return m_lsb ? w[k] : w[m_len - k];
    endfunction

    // behavioural slave: first bit at chip-select fall when cpha=0
    int ecnt;
    always @(posedge cs_act) begin
        ecnt = 0;
        if (!m_cpha) miso = sbit(0, 0);
    end

    // behavioural slave: sample and shift on SCLK edges
    always @(sclk) begin
        int L, fe, f, k;
        if (cs_act) begin
            L  = m_len + 1;
            fe = ecnt % (2 * L);
            f  = ecnt / (2 * L);
            k  = fe / 2;
            if (m_cpha ? (fe % 2 == 1) : (fe % 2 == 0)) begin
                got[f & 7][k] = mosi;
            end else if (m_cpha) begin
                miso = sbit(f, k);
            end else begin
                miso = (k + 1 < L) ? sbit(f, k + 1) : sbit(f + 1, 0);
            end
            ecnt++;
        end
    end

    // timing / edge / result monitor, away from the active edge
    always @(negedge clk) begin
        if (cs_act && !cs_prev) begin
            since = 0; first = 1; lvl_cs = sclk;
        end else if (cs_act && (sclk != sclk_prev)) begin
            if (first) lead = since + 1;
            else begin
                if (since + 1 < hmin) hmin = since + 1;
                if (since + 1 > hmax) hmax = since + 1;
            end
            first = 0; since = 0; edges++;
        end else if (!cs_act && cs_prev) begin
            trail = since + 1;
        end else begin
            since++;
        end
        if (cs_act) cs_mask = cs_mask | ~cs_n;
        if (rx_valid) begin
            chk(rx_data == s_words[mframes & 7], "R7 rx word", int'(rx_data), int'(s_words[mframes & 7]));
            mframes++;
        end
        if (irq) irq_cnt++;
        cs_prev = cs_act; sclk_prev = sclk;
    end

    task automatic cfg(input int dev, input bit cp, input bit ph, input bit ls, input int len, input int dv);
        @(negedge clk);
        cfg_we = 1; cfg_dev = SELW'(dev); cfg_cpol = cp; cfg_cpha = ph;
        cfg_lsb = ls; cfg_len = LENW'(len); cfg_div = DIVW'(dv);
        @(negedge clk);
        cfg_we = 0;
        bp_cpol[dev] = cp; bp_cpha[dev] = ph; bp_lsb[dev] = ls;
        bp_len[dev] = len; bp_div[dev] = dv;
    endtask

    task automatic run(input int dev, input logic [DW-1:0] w, input int burst, input bit ie, input bit poke);
        int L, guard, nd;
        logic [DW-1:0] mask, recv;
        m_cpol = bp_cpol[dev]; m_cpha = bp_cpha[dev]; m_lsb = bp_lsb[dev];
        m_len = bp_len[dev]; nd = bp_div[dev];
        L = m_len + 1;
        mask = (L == DW) ? '1 : DW'((1 << L) - 1);
        for (int f = 0; f < 8; f++) begin
            s_words[f] = DW'($urandom) & mask;
            for (int k = 0; k < DW; k++) got[f][k] = 0;
        end
        edges = 0; mframes = 0; irq_cnt = 0; cs_mask = '0;
        hmin = 1 << 30; hmax = 0; lead = -1; trail = -1;
        @(negedge clk);
        dev_sel = SELW'(dev); tx_data = w; burst_len = BW'(burst);
        irq_en = ie; start_we = 1;
        @(negedge clk);
        start_we = 0;
        if (poke) begin
            repeat (6) @(negedge clk);
            chk(busy == 1, "R10 still busy at poke", int'(busy), 1);
            dev_sel = SELW'((dev + 1) % NCS); tx_data = ~w; burst_len = '0;
            start_we = 1;
            @(negedge clk);
            start_we = 0;
        end
        guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk(done == 1, "R9 done set", int'(done), 1);
        chk(irq_cnt == int'(ie), "R9 irq pulses", irq_cnt, int'(ie));
        chk(mframes == burst + 1, "R8 frame count", mframes, burst + 1);
        chk(edges == 2 * L * (burst + 1), "R5 edge count", edges, 2 * L * (burst + 1));
        chk(lead == nd + 1, "R4 cs lead", lead, nd + 1);
        chk(trail == nd + 1, "R4 cs trail", trail, nd + 1);
        if (edges > 1) begin
            chk(hmin == nd + 1 && hmax == nd + 1, "R4 half period", hmax, nd + 1);
        end
        chk(lvl_cs == m_cpol, "R3 idle level at cs fall", int'(lvl_cs), int'(m_cpol));
        chk(sclk == m_cpol, "R3 idle level after", int'(sclk), int'(m_cpol));
        chk(cs_mask == NCS'(1 << dev), "R2 selected line", int'(cs_mask), 1 << dev);
        for (int f = 0; f <= burst; f++) begin
            recv = '0;
            for (int k = 0; k < L; k++) recv[m_lsb ? k : m_len - k] = got[f][k];
            chk(recv == (w & mask), "R6 wire order mosi", int'(recv), int'(w & mask));
        end
        if (poke) chk(busy == 0, "R10 no restart", int'(busy), 0);
        @(negedge clk);
        rd_ack = 1;
        @(negedge clk);
        rd_ack = 0;
        chk(done == 0, "R9 done cleared by rd_ack", int'(done), 0);
    endtask

    task automatic abort_test();
        cfg(0, 1, 0, 0, DW - 1, 3);
        m_cpol = 1; m_cpha = 0; m_lsb = 0; m_len = DW - 1;
        @(negedge clk);
        dev_sel = 0; tx_data = 16'h1234; burst_len = 3; irq_en = 1; start_we = 1;
        @(negedge clk);
        start_we = 0;
        repeat (20) @(negedge clk);
        abort = 1;
        @(negedge clk);
        abort = 0;
        chk(&cs_n, "R11 cs released", int'(cs_n), (1 << NCS) - 1);
        chk(busy == 0, "R11 busy cleared", int'(busy), 0);
        chk(sclk == 1'b1, "R11 sclk idle", int'(sclk), 1);
        repeat (3) @(negedge clk);
        chk(done == 0, "R11 done not set", int'(done), 0);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        int seed, dev;
        seed = $urandom(32'h5A17);
        for (int i = 0; i < NCS; i++) begin
            bp_cpol[i] = 0; bp_cpha[i] = 0; bp_lsb[i] = 0; bp_len[i] = DW - 1; bp_div[i] = 0;
        end
        rst_n = 0; cfg_we = 0; cfg_dev = 0; cfg_cpol = 0; cfg_cpha = 0; cfg_lsb = 0;
        cfg_len = 0; cfg_div = 0; start_we = 0; dev_sel = 0; tx_data = 0;
        burst_len = 0; irq_en = 0; rd_ack = 0; abort = 0; miso = 0;
        m_cpol = 0; m_cpha = 0; m_lsb = 0; m_len = DW - 1;
        cs_prev = 0; sclk_prev = 0;
        repeat (3) @(negedge clk);
        chk(&cs_n, "R1 cs_n reset", int'(cs_n), (1 << NCS) - 1);
        chk(sclk == 0 && mosi == 0, "R1 sclk/mosi reset", int'({sclk, mosi}), 0);
        chk(busy == 0 && done == 0 && irq == 0 && rx_valid == 0, "R1 flags reset",
            int'({busy, done, irq, rx_valid}), 0);
        rst_n = 1;
        @(negedge clk);
        // R1: reset profile is mode 0, MSB first, full width, divider 0
        run(0, 16'hA5C3, 0, 1, 0);
        cfg(1, 1, 1, 1, 7, 2);
        cfg(2, 0, 1, 0, 0, 1);
        cfg(3, 1, 0, 1, 10, 0);
        run(1, 16'h00B7, 0, 1, 0);
        run(2, 16'hFFFF, 1, 0, 0);
        run(3, 16'h7A5, 0, 1, 0);
        run(0, 16'h8001, 0, 0, 0);
        run(1, 16'hC3C3, 7, 1, 0);
        cfg(3, 0, 1, 0, DW - 1, 1);
        run(3, 16'h5AF0, 2, 0, 1);
        cfg(2, 0, 0, 0, 7, 0);
        run(2, 16'h0081, 0, 0, 0);
        cfg(2, 0, 0, 1, 7, 0);
        run(2, 16'h0081, 0, 0, 0);
        abort_test();
        run(0, 16'h3C5A, 1, 1, 0);
        for (int n = 0; n < 30; n++) begin
            dev = $urandom_range(NCS - 1);
            if ($urandom_range(1) == 1) begin
                cfg(dev, 1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                    $urandom_range(DW - 1), $urandom_range(3));
            end
            run(dev, DW'($urandom), $urandom_range(3), 1'($urandom_range(1)), 0);
        end
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule